// File: doc/BRIEF.md
# Functional Test Replay Controller with Mode Forcing

This block wraps a small group of control-point register bits and observation-point register bits inside a larger circuit under test. It replays one externally supplied functional pattern sequence several times in a row. The first replay runs with every control point free. Each later replay runs with the control points forced to one stored truth assignment, called a mode. The number of patterns per replay, N, and the number of forced replays, M, are loaded from configuration inputs when a run starts, so a run lasts N × (M+1) pattern slots.

The control-point flops live in this block. Each bit has a two-way select on its D input: either the functional next-state from the surrounding logic or the forced value. One short scan chain carries both sets of bits. The control-point section sits next to the serial input and the observation section sits next to the serial output. The two sections have the same length K, so K shift cycles do two jobs at once. They move the previous replay's captured observation word out, most significant bit first, and they move the next mode in. The shadow chain is kept apart from the circuit's own flops, so shifting never alters functional state. Up to NMODES modes are held in local registers, written through a simple write port.

Top module: `tmx_ctrl`

## Requirements
- R1: After a synchronous reset, `pat_req`, `scan_vld`, `done` and `busy` are low and `cp_q` is all zeros.
- R2: A `start` pulse while idle or done begins a run of M+1 replays. `pass_idx` is 0 during the free replay and p during the replay forced with stored mode p-1.
- R3: Each replay raises `pat_req` for exactly N consecutive cycles, so a run issues N × (M+1) requests. N = 0 is legal and gives replays with no requests.
- R4: Throughout every request cycle of forced replay p, `cp_q[i]` equals bit i of the mode written at index p-1 through `mode_wr_*`.
- R5: Outside forced replays, `cp_q` loads `func_next` on every clock.
- R6: `obs_in` is captured into the chain in the cycle after a replay's last request. Over the next K cycles, with `scan_vld` high, it appears on `scan_out` one bit per cycle, bit K-1 first.
- R7: The response of replay p shifts out in the same K cycles that shift in the mode for replay p+1. After the last replay, one more K-cycle unload shifts in zeros, and then `done` rises.
- R8: `cp_q` does not change between consecutive cycles that both have `scan_vld` high, as long as `func_next` equals `cp_q` during those cycles.
- R9: A `cfg_nmode` value above NMODES is treated as NMODES.
- R10: Changes on `cfg_npat` and `cfg_nmode` after `start` have no effect on the run in progress.
- R11: When a run ends, `done` stays high and `busy` stays low until the next `start`. A `start` in that state begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (one-cycle pulse) |
| cfg_npat | input | CNT_W | Patterns per replay, N |
| cfg_nmode | input | MODE_W | Forced replays per run, M |
| mode_wr_en | input | 1 | Write enable for mode storage |
| mode_wr_idx | input | IDX_W | Mode entry to write |
| mode_wr_data | input | NCP | Mode value, bit i forces control point i |
| func_next | input | NCP | Functional next-state of the control-point bits |
| obs_in | input | NCP | Current observation-point values |
| cp_q | output | NCP | Control-point register bits |
| pat_req | output | 1 | Request the next functional pattern this cycle |
| pass_idx | output | MODE_W | Current replay number |
| scan_out | output | 1 | Serial response bit |
| scan_vld | output | 1 | `scan_out` holds a response bit this cycle |
| done | output | 1 | Run complete |
| busy | output | 1 | Run in progress |

## Verification
The hardest case to reach is the alignment between the response leaving the chain and the mode entering it during the same shifts. An off-by-one error in bit order or in the mode index shows up only in the response of a later forced replay, and only when the forced values change what the circuit computes. The bench places a small circuit model around the block. In that model the control points gate and feed the observation logic, and the circuit's state carries over from one replay to the next. As a result, every shifted-out word depends on the exact mode that was applied and on all earlier replays. Runs with N = 0, with M = 0, with a clamped M, and with the configuration changed mid-run cover the sequencing boundaries.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_UNLOAD,
    ST_DONE
  } tmx_state_e;
endpackage

// File: rtl/tmx_mode_bank.sv
module tmx_mode_bank #(
  parameter int NCP    = 4,
  parameter int NMODES = 4,
  localparam int IDX_W = (NMODES > 1) ? $clog2(NMODES) : 1,
  localparam int SH_W  = $clog2(NCP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [NCP-1:0]   wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [SH_W-1:0]  rd_bit,
  output logic             rd_val
);
  logic [NCP-1:0] bank [NMODES];

  for (genvar g = 0; g < NMODES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) bank[g] <= '0;
      else if (wr_en && (int'(wr_idx) == g)) bank[g] <= wr_data;
    end
  end

  logic [NCP-1:0] sel_word;
  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NMODES; i++)
      if (int'(rd_idx) == i) sel_word = bank[i];
  end

  assign rd_val = sel_word[rd_bit];
endmodule

// File: rtl/tmx_scan_link.sv
module tmx_scan_link #(
  parameter int NCP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           capture,
  input  logic           sin,
  input  logic [NCP-1:0] obs_in,
  output logic           scan_out,
  output logic [NCP-1:0] cp_img,
  output logic [NCP-1:0] cp_after_shift
);
  localparam int LEN = 2 * NCP;
  logic [LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else if (shift_en) chain <= {chain[LEN-2:0], sin};
    else if (capture) chain[LEN-1:NCP] <= obs_in;
  end

  assign scan_out       = chain[LEN-1];
  assign cp_img         = chain[NCP-1:0];
  assign cp_after_shift = {chain[NCP-2:0], sin};

  assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
    capture |=> (scan_out == $past(obs_in[NCP-1])));
endmodule

// File: rtl/tmx_cp_force.sv
module tmx_cp_force #(
  parameter int NCP = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel,
  input  logic [NCP-1:0] force_val,
  input  logic [NCP-1:0] func_next,
  output logic [NCP-1:0] q
);
  for (genvar b = 0; b < NCP; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[b] <= 1'b0;
      else q[b] <= sel ? force_val[b] : func_next[b];
    end
  end
endmodule

// File: rtl/tmx_seq.sv
module tmx_seq
  import tmx_pkg::*;
#(
  parameter int NCP    = 4,
  parameter int NMODES = 4,
  parameter int CNT_W  = 8,
  localparam int MODE_W = $clog2(NMODES + 1),
  localparam int SH_W   = $clog2(NCP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_npat,
  input  logic [MODE_W-1:0] cfg_nmode,
  output logic              pat_req,
  output logic              capture,
  output logic              shift_en,
  output logic              shift_mode,
  output logic              load_last,
  output logic              force_hold,
  output logic [MODE_W-1:0] pass_idx,
  output logic [SH_W-1:0]   sh_cnt,
  output logic              done,
  output logic              busy
);
  localparam logic [MODE_W-1:0] MAXM = MODE_W'(NMODES);

  tmx_state_e        st;
  logic [CNT_W-1:0]  pat_cnt, npat_l;
  logic [MODE_W-1:0] nmode_l, pass;
  logic              sh_last;

  assign sh_last = (sh_cnt == SH_W'(NCP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; pat_cnt <= '0; npat_l <= '0; nmode_l <= '0;
      pass <= '0; sh_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: if (start) begin
          npat_l  <= cfg_npat;
          nmode_l <= (cfg_nmode > MAXM) ? MAXM : cfg_nmode;
          pass    <= '0;
          pat_cnt <= '0;
          st      <= ST_RUN;
        end
        ST_RUN: begin
          if (pat_cnt == npat_l) begin
            pat_cnt <= '0;
            sh_cnt  <= '0;
            st      <= (pass == nmode_l) ? ST_UNLOAD : ST_LOAD;
          end else begin
            pat_cnt <= pat_cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          sh_cnt <= sh_cnt + 1'b1;
          if (sh_last) begin
            pass <= pass + 1'b1;
            st   <= ST_RUN;
          end
        end
        ST_UNLOAD: begin
          sh_cnt <= sh_cnt + 1'b1;
          if (sh_last) st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pat_req    = (st == ST_RUN) && (pat_cnt != npat_l);
  assign capture    = (st == ST_RUN) && (pat_cnt == npat_l);
  assign shift_en   = (st == ST_LOAD) || (st == ST_UNLOAD);
  assign shift_mode = (st == ST_LOAD);
  assign load_last  = (st == ST_LOAD) && sh_last;
  assign force_hold = (st == ST_RUN) && (pass != '0);
  assign pass_idx   = pass;
  assign done       = (st == ST_DONE);
  assign busy       = (st == ST_RUN) || shift_en;

  assert_cnt_le_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> (pat_cnt <= npat_l));
  assert_pass_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (pass <= nmode_l) && (nmode_l <= MAXM));
  assert_capture_then_shift_R7: assert property (@(posedge clk) disable iff (rst)
    capture |=> shift_en);
  assert_done_after_unload_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(st) == ST_UNLOAD));
endmodule

// File: rtl/tmx_ctrl.sv
module tmx_ctrl #(
  parameter int NCP    = 4,
  parameter int NMODES = 4,
  parameter int CNT_W  = 8,
  localparam int MODE_W = $clog2(NMODES + 1),
  localparam int IDX_W  = (NMODES > 1) ? $clog2(NMODES) : 1,
  localparam int SH_W   = $clog2(NCP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_npat,
  input  logic [MODE_W-1:0] cfg_nmode,
  input  logic              mode_wr_en,
  input  logic [IDX_W-1:0]  mode_wr_idx,
  input  logic [NCP-1:0]    mode_wr_data,
  input  logic [NCP-1:0]    func_next,
  input  logic [NCP-1:0]    obs_in,
  output logic [NCP-1:0]    cp_q,
  output logic              pat_req,
  output logic [MODE_W-1:0] pass_idx,
  output logic              scan_out,
  output logic              scan_vld,
  output logic              done,
  output logic              busy
);
  logic            capture, shift_en, shift_mode, load_last, force_hold;
  logic [SH_W-1:0] sh_cnt;
  logic            mode_bit, sin, force_sel;
  logic [NCP-1:0]  cp_img, cp_after_shift, force_val;

  tmx_seq #(.NCP(NCP), .NMODES(NMODES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_npat(cfg_npat), .cfg_nmode(cfg_nmode),
    .pat_req(pat_req), .capture(capture), .shift_en(shift_en), .shift_mode(shift_mode),
    .load_last(load_last), .force_hold(force_hold), .pass_idx(pass_idx),
    .sh_cnt(sh_cnt), .done(done), .busy(busy)
  );

  tmx_mode_bank #(.NCP(NCP), .NMODES(NMODES)) u_bank (
    .clk(clk), .rst(rst), .wr_en(mode_wr_en), .wr_idx(mode_wr_idx),
    .wr_data(mode_wr_data), .rd_idx(pass_idx[IDX_W-1:0]),
    .rd_bit(SH_W'(NCP - 1) - sh_cnt), .rd_val(mode_bit)
  );

  assign sin = shift_mode & mode_bit;

  tmx_scan_link #(.NCP(NCP)) u_chain (
    .clk(clk), .rst(rst), .shift_en(shift_en), .capture(capture), .sin(sin),
    .obs_in(obs_in), .scan_out(scan_out), .cp_img(cp_img),
    .cp_after_shift(cp_after_shift)
  );

  assign force_sel = load_last | force_hold;
  assign force_val = load_last ? cp_after_shift : cp_img;

  tmx_cp_force #(.NCP(NCP)) u_force (
    .clk(clk), .rst(rst), .sel(force_sel), .force_val(force_val),
    .func_next(func_next), .q(cp_q)
  );

  assign scan_vld = shift_en;

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (force_hold && $past(force_hold)) |-> $stable(cp_q));
  assert_free_follow_R5: assert property (@(posedge clk) disable iff (rst)
    (!force_sel && !$past(rst)) |=> (cp_q == $past(func_next)));
endmodule

// File: tb/tmx_ctrl_test.sv
`timescale 1ns/1ps
module tmx_ctrl_test;
  localparam int K = 4, NM = 4, CW = 8;
  localparam int MW = $clog2(NM + 1), IW = $clog2(NM);

  logic clk = 0, rst = 1, start = 0, mode_wr_en = 0;
  logic [CW-1:0] cfg_npat = '0;
  logic [MW-1:0] cfg_nmode = '0;
  logic [IW-1:0] mode_wr_idx = '0;
  logic [K-1:0]  mode_wr_data = '0, func_next, obs_in, cp_q;
  logic pat_req, scan_out, scan_vld, done, busy;
  logic [MW-1:0] pass_idx;

  always #4 clk = ~clk;

  tmx_ctrl #(.NCP(K), .NMODES(NM), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .cfg_npat(cfg_npat), .cfg_nmode(cfg_nmode),
    .mode_wr_en(mode_wr_en), .mode_wr_idx(mode_wr_idx), .mode_wr_data(mode_wr_data),
    .func_next(func_next), .obs_in(obs_in), .cp_q(cp_q), .pat_req(pat_req),
    .pass_idx(pass_idx), .scan_out(scan_out), .scan_vld(scan_vld), .done(done), .busy(busy)
  );

  function automatic logic [3:0] f_cp(logic [3:0] c, logic [3:0] p);
    return {c[2:0], c[3]} ^ p;
  endfunction
  function automatic logic [3:0] g_obs(logic [3:0] r, logic [3:0] p, logic [3:0] c);
    return {r[2:0], r[3] ^ r[1]} ^ (p & ~c) ^ {c[0], c[3] & p[1], c[1], c[2] ^ p[0]};
  endfunction
  function automatic logic [3:0] pat_of(int i);
    return 4'((i * 7 + 3) % 16);
  endfunction

  // toy circuit under test
  logic [3:0] r;
  int pidx;
  logic [3:0] pat;
  assign pat = pat_of(pidx);
  assign func_next = pat_req ? f_cp(cp_q, pat) : cp_q;
  assign obs_in = r;
  always_ff @(posedge clk) begin
    if (rst) begin r <= '0; pidx <= 0; end
    else begin
      if (pat_req) r <= g_obs(r, pat, cp_q);
      pidx <= pat_req ? pidx + 1 : 0;
    end
  end

  int total = 0, bad = 0;
  logic [3:0] modes [NM];
  logic [3:0] exp_resp [8];
  logic [3:0] m_cp = '0, m_r = '0;
  int slot_total, slot_pp [8], wn, bitn, hold_bad, stab_bad;
  logic [3:0] shreg, prev_cp;
  logic prev_vld = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (pat_req) begin
        slot_total++;
        slot_pp[pass_idx]++;
        if (pass_idx != 0 && cp_q != modes[pass_idx - 1]) hold_bad++;
      end
      if (scan_vld) begin
        if (prev_vld && cp_q != prev_cp) stab_bad++;
        shreg = {shreg[2:0], scan_out};
        bitn++;
        if (bitn == K) begin
          // word 0 checks the free replay (R5), later words the forced ones
          chk(wn < 8 && shreg == exp_resp[wn & 7], "R6 R5", "response word",
              int'(shreg), int'(exp_resp[wn & 7]));
          wn++;
          bitn = 0;
        end
      end
      prev_vld = scan_vld;
      prev_cp  = cp_q;
    end
  end

  task automatic reset_check();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!pat_req && !scan_vld && !done && !busy, "R1", "control outputs after reset",
        {pat_req, scan_vld, done, busy}, 0);
    chk(cp_q == 0, "R1", "cp_q after reset", int'(cp_q), 0);
  endtask

  task automatic write_modes();
    logic [3:0] mv [4] = '{4'b1010, 4'b0111, 4'b0001, 4'b1100};
    for (int i = 0; i < NM; i++) begin
      @(posedge clk); #1;
      mode_wr_en = 1; mode_wr_idx = IW'(i); mode_wr_data = mv[i]; modes[i] = mv[i];
    end
    @(posedge clk); #1 mode_wr_en = 0;
  endtask

  task automatic run_case(string name, int n, int m_cfg, int m_eff, bit disturb);
    int guard;
    for (int p = 0; p <= m_eff; p++) begin
      if (p > 0) m_cp = modes[p - 1];
      for (int i = 0; i < n; i++) begin
        logic [3:0] nr;
        nr = g_obs(m_r, pat_of(i), m_cp);
        if (p == 0) m_cp = f_cp(m_cp, pat_of(i));
        m_r = nr;
      end
      exp_resp[p] = m_r;
    end
    @(posedge clk); #1;
    slot_total = 0; wn = 0; bitn = 0; hold_bad = 0; stab_bad = 0;
    for (int j = 0; j < 8; j++) slot_pp[j] = 0;
    cfg_npat = CW'(n); cfg_nmode = MW'(m_cfg); start = 1;
    @(posedge clk); #1 start = 0;
    if (disturb) begin cfg_npat = CW'(n + 4); cfg_nmode = MW'(0); end
    guard = 0;
    while (!done && guard < 5000) begin @(posedge clk); guard++; end
    @(negedge clk);
    chk(slot_total == n * (m_eff + 1), "R3", {name, " total requests"}, slot_total, n * (m_eff + 1));
    for (int j = 0; j <= m_eff; j++)
      chk(slot_pp[j] == n, "R2", {name, " requests in replay"}, slot_pp[j], n);
    chk(wn == m_eff + 1, "R7", {name, " words unloaded"}, wn, m_eff + 1);
    chk(hold_bad == 0, "R4", {name, " forced value mismatches"}, hold_bad, 0);
    chk(stab_bad == 0, "R8", {name, " cp_q changes while shifting"}, stab_bad, 0);
    chk(done && !busy, "R11", {name, " done/busy at end"}, {done, busy}, 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done && !busy, "R11", {name, " done held"}, {done, busy}, 2);
  endtask

  initial begin
    #(8 * 190000);
    bad++; total++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    reset_check();
    write_modes();
    run_case("n5m3", 5, 3, 3, 0);        // R2 R3: 20 slots
    run_case("n3m0", 3, 0, 0, 0);        // R7: free replay only
    run_case("n0m2", 0, 2, 2, 0);        // R3: empty replays
    run_case("clamp", 2, 7, NM, 0);      // R9: M above limit
    run_case("latched", 4, 2, 2, 1);     // R10: config changed mid-run
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule